// File: doc/BRIEF.md
# Stuck-Cell Line Repair by Bit Pointers

This block repairs permanently stuck cells in a single 512-bit memory line. It keeps a small, fixed bank of correction slots. Each slot records one faulty bit position and the value that position ought to read back. A clean line consumes no slots; slots are claimed only as faults show up.

Faults are found at write time. The surrounding controller writes the line, reads it straight back, and presents the intended data and the read-back together with a write strobe. Every bit that differs and is not already covered by a slot claims the next free slot. On a read, the raw line from the array passes through a combinational substitution stage. That stage overwrites every pointed position with its stored bit. When the faults outrun the free slots, the block raises an uncorrectable pulse and leaves its state alone.

Top module: `stuck_line_repair`

## Requirements
- R1: After reset every slot is invalid, `full` and `uncorr` are 0, and `rd_data` equals `rd_raw`.
- R2: A write whose read-back equals the intended data claims no slot.
- R3: Each new failing position claims its own slot. A new failing position is one where `wr_data` and `rb_data` differ and no valid slot points at it. Slots are claimed from the lowest free index upward. Several new positions in one write go to increasing slot indices in increasing bit-position order, where position k is bit k of the line and bit 0 is the LSB. The slot's pointer is the position and its stored bit is `wr_data` at that position.
- R4: A mismatch at a position that a valid slot already points at claims no further slot.
- R5: On every accepted write, each previously valid slot reloads its stored bit from `wr_data` at its pointed position.
- R6: `rd_data` equals `rd_raw` except at positions pointed at by valid slots, which carry the stored bit. This path is combinational within the same cycle, and where two valid slots name one position, the higher index wins.
- R7: `full` rises after the write that claims the last slot, index N_ENT-1, and stays high until reset.
- R8: In some writes the number of new failing positions exceeds the free slots, for example any new failure while `full` is 1. For such a write, `uncorr` is 1 for exactly the cycle after it, and no slot's valid flag, pointer or stored bit changes.
- R9: Without `wr_en` no slot state changes, and a valid slot keeps its pointer until reset.
- R10: Slot i is reported on `ent_valid[i]`, `ent_bit[i]` and `ent_ptr[i*9 +: 9]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write with verify read-back presented this cycle |
| wr_data | input | 512 | Intended line data |
| rb_data | input | 512 | Line read back from the array after the write |
| rd_raw | input | 512 | Raw line read from the array |
| rd_data | output | 512 | Corrected line |
| ent_valid | output | N_ENT | Per-slot valid flags |
| ent_ptr | output | N_ENT*9 | Per-slot bit-position pointers, packed |
| ent_bit | output | N_ENT | Per-slot stored replacement bits |
| full | output | 1 | Last slot has been claimed |
| uncorr | output | 1 | Previous write had more new faults than free slots |

## Verification
The assertions check several properties on every cycle:
- slot occupancy stays contiguous from index 0;
- pointers never move once set, and `full` never drops;
- slot state never changes without a write or across an uncorrectable write;
- the fault picker emits positions in rising order;
- the read stage alters at most N_ENT bits.

Only the bench scenarios can show that the picked pointers and stored bits are the right values, that covered mismatches are ignored, and that stored bits are refreshed on each write. They also show that a rejected write leaves the old stored bits intact.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int LINE_W = 512;
    localparam int PTR_W  = $clog2(LINE_W);
    localparam int CNT_W  = $clog2(LINE_W + 1);

    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        logic vld;
        ptr_t ptr;
        logic fix;
    } slot_t;

    // Lowest set bit position of a line-wide vector (0 when empty).
    function automatic ptr_t lowest_set(input logic [LINE_W-1:0] v);
        ptr_t r;
        r = '0;
        for (int i = LINE_W - 1; i >= 0; i--) begin
            if (v[i]) r = ptr_t'(i);
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] pop_line(input logic [LINE_W-1:0] v);
        return CNT_W'($countones(v));
    endfunction
endpackage

// File: rtl/slc_fault_find.sv
module slc_fault_find import slc_pkg::*; #(
    parameter int N_ENT = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LINE_W-1:0]       wr_data,
    input  logic [LINE_W-1:0]       rb_data,
    input  logic [LINE_W-1:0]       covered,
    output logic [CNT_W-1:0]        new_cnt,
    output ptr_t [N_ENT-1:0]        pick_pos
);
    logic [LINE_W-1:0] rem [N_ENT];
    logic [N_ENT-1:0]  pick_ok;

    assign rem[0]  = (wr_data ^ rb_data) & ~covered;
    assign new_cnt = pop_line(rem[0]);

    // Chain of lowest-bit pickers: stage k takes the k-th lowest new fault.
    for (genvar k = 0; k < N_ENT; k++) begin : g_pick
        assign pick_pos[k] = lowest_set(rem[k]);
        assign pick_ok[k]  = |rem[k];
        if (k + 1 < N_ENT) begin : g_next
            assign rem[k+1] = rem[k] & ~(LINE_W'(1) << pick_pos[k]);
        end
        if (k > 0) begin : g_chk
            assert_pick_order_R3: assert property (@(posedge clk) disable iff (rst)
                pick_ok[k] |-> (pick_ok[k-1] && (pick_pos[k-1] < pick_pos[k])));
        end
    end
endmodule

// File: rtl/slc_slot_bank.sv
module slc_slot_bank import slc_pkg::*; #(
    parameter int N_ENT = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [LINE_W-1:0]   wr_data,
    input  logic [CNT_W-1:0]    new_cnt,
    input  ptr_t [N_ENT-1:0]    pick_pos,
    output slot_t [N_ENT-1:0]   slots,
    output logic [LINE_W-1:0]   covered,
    output logic                full,
    output logic                uncorr
);
    localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    slot_t [N_ENT-1:0] slot_q, slot_d;
    logic              full_q, uncorr_q;
    logic              overflow;
    int                used_n;

    always_comb begin
        covered = '0;
        used_n  = 0;
        for (int i = 0; i < N_ENT; i++) begin
            if (slot_q[i].vld) begin
                covered[slot_q[i].ptr] = 1'b1;
                used_n = used_n + 1;
            end
        end
    end

    assign overflow = wr_en && (int'(new_cnt) > (N_ENT - used_n));

    always_comb begin
        slot_d = slot_q;
        if (wr_en && !overflow) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (slot_q[i].vld) begin
                    slot_d[i].fix = wr_data[slot_q[i].ptr];
                end else if ((i - used_n) < int'(new_cnt)) begin
                    slot_d[i].vld = 1'b1;
                    slot_d[i].ptr = pick_pos[SEL_W'(i - used_n)];
                    slot_d[i].fix = wr_data[pick_pos[SEL_W'(i - used_n)]];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            full_q   <= 1'b0;
            uncorr_q <= 1'b0;
        end else begin
            slot_q   <= slot_d;
            full_q   <= full_q | slot_d[N_ENT-1].vld;
            uncorr_q <= overflow;
        end
    end

    assign slots  = slot_q;
    assign full   = full_q;
    assign uncorr = uncorr_q;

    for (genvar i = 0; i < N_ENT; i++) begin : g_chk
        if (i > 0) begin : g_thermo
            assert_fill_order_R3: assert property (@(posedge clk) disable iff (rst)
                slot_q[i].vld |-> slot_q[i-1].vld);
        end
        assert_ptr_kept_R9: assert property (@(posedge clk) disable iff (rst)
            slot_q[i].vld |=> (slot_q[i].vld && $stable(slot_q[i].ptr)));
    end

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(slot_q));
    assert_reject_hold_R8: assert property (@(posedge clk) disable iff (rst)
        uncorr_q |-> ($stable(slot_q) && $stable(full_q)));
    assert_full_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        full_q |=> full_q);
endmodule

// File: rtl/slc_read_fix.sv
module slc_read_fix import slc_pkg::*; #(
    parameter int N_ENT = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINE_W-1:0]   rd_raw,
    input  slot_t [N_ENT-1:0]   slots,
    output logic [LINE_W-1:0]   rd_data
);
    // Ascending walk: a later (higher) slot overrides an earlier one.
    always_comb begin
        rd_data = rd_raw;
        for (int i = 0; i < N_ENT; i++) begin
            if (slots[i].vld) rd_data[slots[i].ptr] = slots[i].fix;
        end
    end

    assert_fix_span_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_raw ^ rd_data) <= N_ENT);
endmodule

// File: rtl/stuck_line_repair.sv
module stuck_line_repair import slc_pkg::*; #(
    parameter int N_ENT = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [LINE_W-1:0]        wr_data,
    input  logic [LINE_W-1:0]        rb_data,
    input  logic [LINE_W-1:0]        rd_raw,
    output logic [LINE_W-1:0]        rd_data,
    output logic [N_ENT-1:0]         ent_valid,
    output logic [N_ENT*PTR_W-1:0]   ent_ptr,
    output logic [N_ENT-1:0]         ent_bit,
    output logic                     full,
    output logic                     uncorr
);
    logic [LINE_W-1:0]  covered;
    logic [CNT_W-1:0]   new_cnt;
    ptr_t [N_ENT-1:0]   pick_pos;
    slot_t [N_ENT-1:0]  slots;

    slc_fault_find #(.N_ENT(N_ENT)) u_find (
        .clk(clk), .rst(rst), .wr_data(wr_data), .rb_data(rb_data),
        .covered(covered), .new_cnt(new_cnt), .pick_pos(pick_pos)
    );

    slc_slot_bank #(.N_ENT(N_ENT)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .new_cnt(new_cnt), .pick_pos(pick_pos), .slots(slots),
        .covered(covered), .full(full), .uncorr(uncorr)
    );

    slc_read_fix #(.N_ENT(N_ENT)) u_fix (
        .clk(clk), .rst(rst), .rd_raw(rd_raw), .slots(slots), .rd_data(rd_data)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_out
        assign ent_valid[i]               = slots[i].vld;
        assign ent_bit[i]                 = slots[i].fix;
        assign ent_ptr[i*PTR_W +: PTR_W]  = slots[i].ptr;
    end

    assert_uncorr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (uncorr && !wr_en) |=> !uncorr);
endmodule

// File: tb/test_stuck_line_repair.sv
`timescale 1ns/1ps
module test_stuck_line_repair;
    localparam int N  = 6;
    localparam int LW = 512;
    localparam int PW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [LW-1:0] wr_data = '0, rb_data = '0, rd_raw = '0;
    logic [LW-1:0] rd_data;
    logic [N-1:0]  ent_valid, ent_bit;
    logic [N*PW-1:0] ent_ptr;
    logic full, uncorr;

    int checks = 0;
    int errors = 0;

    bit m_vld [N];
    int m_ptr [N];
    bit m_fix [N];
    bit m_full;
    bit m_uncorr;
    logic [LW-1:0] pat;

    always #2.5 clk = ~clk;

    stuck_line_repair #(.N_ENT(N)) i_stuck_line_repair (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rb_data(rb_data),
        .rd_raw(rd_raw), .rd_data(rd_data), .ent_valid(ent_valid), .ent_ptr(ent_ptr),
        .ent_bit(ent_bit), .full(full), .uncorr(uncorr)
    );

    task automatic chk(input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] bits3(input int a, input int b, input int c);
        logic [LW-1:0] v;
        v = '0;
        if (a >= 0) v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        return v;
    endfunction

    // Slot fields read through the packed ports (R10 layout).
    task automatic check_state(input string req);
        for (int i = 0; i < N; i++) begin
            chk(req, $sformatf("valid[%0d]", i), LW'(ent_valid[i]), LW'(m_vld[i]));
            if (m_vld[i]) begin
                chk({req, "/R10"}, $sformatf("ptr[%0d]", i), LW'(ent_ptr[i*PW +: PW]), LW'(m_ptr[i]));
                chk(req, $sformatf("bit[%0d]", i), LW'(ent_bit[i]), LW'(m_fix[i]));
            end
        end
        chk(req, "full", LW'(full), LW'(m_full));
        chk(req, "uncorr", LW'(uncorr), LW'(m_uncorr));
    endtask

    task automatic check_read(input logic [LW-1:0] raw, input string req);
        logic [LW-1:0] exp;
        rd_raw = raw;
        #1;
        exp = raw;
        for (int i = 0; i < N; i++) if (m_vld[i]) exp[m_ptr[i]] = m_fix[i];
        chk(req, "rd_data", rd_data, exp);
    endtask

    // Apply one write with its verify read-back; update the model from R3-R8.
    task automatic do_write(input logic [LW-1:0] w, input logic [LW-1:0] r, input string req);
        int newp [LW];
        int n, used;
        bit cov;
        n = 0;
        used = 0;
        for (int i = 0; i < N; i++) if (m_vld[i]) used++;
        for (int b = 0; b < LW; b++) begin
            cov = 1'b0;
            for (int i = 0; i < N; i++) if (m_vld[i] && m_ptr[i] == b) cov = 1'b1;
            if (w[b] != r[b] && !cov) begin
                newp[n] = b;
                n++;
            end
        end
        if (n > N - used) begin
            m_uncorr = 1'b1;
        end else begin
            m_uncorr = 1'b0;
            for (int i = 0; i < N; i++) if (m_vld[i]) m_fix[i] = w[m_ptr[i]];
            for (int k = 0; k < n; k++) begin
                m_vld[used+k] = 1'b1;
                m_ptr[used+k] = newp[k];
                m_fix[used+k] = w[newp[k]];
            end
            if (m_vld[N-1]) m_full = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b1; wr_data = w; rb_data = r;
        @(negedge clk);
        wr_en = 1'b0;
        check_state(req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1");
        check_read(~pat, "R1");
    endtask

    task automatic t_clean;
        do_write(pat, pat, "R2");
        do_write(~pat, ~pat, "R2");
    endtask

    task automatic t_single;
        do_write(bits3(37, -1, -1), '0, "R3");
        check_read('0, "R6");
        check_read('1, "R6");
    endtask

    task automatic t_covered;
        logic [LW-1:0] w;
        w = pat & ~bits3(37, -1, -1);
        do_write(w, w, "R5");
        do_write(w | bits3(37, -1, -1), w, "R4");
    endtask

    task automatic t_multi;
        do_write(pat, pat ^ bits3(500, 3, 200), "R3");
        check_read(pat, "R6");
    endtask

    task automatic t_overflow;
        logic [LW-1:0] w;
        w = pat & ~bits3(37, -1, -1);
        do_write(w, w ^ bits3(10, 20, 30), "R8");
        m_uncorr = 1'b0;
        @(negedge clk);
        chk("R8", "uncorr pulse end", LW'(uncorr), '0);
    endtask

    task automatic t_fill;
        do_write(pat, pat ^ bits3(510, 0, -1), "R7");
        check_read(~pat, "R6");
        do_write(pat, pat ^ bits3(77, -1, -1), "R8");
        m_uncorr = 1'b0;
        @(negedge clk);
        check_state("R7");
    endtask

    task automatic t_idle;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            wr_data = pat ^ LW'(k * 97 + 5);
            rb_data = ~wr_data;
        end
        @(negedge clk);
        check_state("R9");
    endtask

    initial begin
        for (int i = 0; i < LW; i++) pat[i] = (((i * 7 + 3) % 5) < 2);
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_ptr[i] = 0; m_fix[i] = 1'b0;
        end
        m_full = 1'b0;
        m_uncorr = 1'b0;
        t_reset();
        t_clean();
        t_single();
        t_covered();
        t_multi();
        t_overflow();
        t_fill();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule